// File: doc/BRIEF.md
# Standby Power Sequencer

This block is the always-on controller that decides whether the main ("working") supply of a chip is on. It runs on the slow standby clock and drives two registered enables: one for the main supply and one for an auxiliary rail. It moves between a reset-standby state, the working state, three kinds of standby (one entered on request, one after a fault, one after a restart), and a timed return to working.

A request entry happens when the sleep-clock indication is raised and at least one of the two power-off enables is set. A fault entry is taken when faults are enabled and any fault input is high. A restart entry is taken when any reset source is high. Fault and restart entries return every unlocked configuration group to its default and abort any request entry or request return in progress. Each kind of standby has its own wake rule and its own return delay. The return completes only while no hold condition (supply invalid or working-domain reset) is present. Configuration is written directly through a write strobe, and a group can be locked by a write until the next reset.

Top module: `sby_pwr_seq`

## Requirements
- R1: While `rst` is high, and on the edge that samples it, `state_o` becomes 0 (reset standby), both enables go low, all configuration takes its defaults (request delay 3, fault delay 5, all enables 0) and all locks clear.
- R2: In reset standby, only a power-button rising edge leaves the state, going to return (`state_o`=5) with the fault delay; other wake events leave it in state 0. In working (`state_o`=1) both enables are high.
- R3: In working, with the sleep-clock indication high and at least one off enable set, the block enters request standby (`state_o`=2) with `main_en` = NOT main-off enable and `aux_en` = NOT aux-off enable; with both off enables clear it stays in working.
- R4: In request standby, a rising edge on the power button or on the wake-event input starts a return loaded with the request delay.
- R5: With faults enabled, any bit of `fault_req` sends working or request standby to fault standby (`state_o`=3) with both enables low; with faults disabled `fault_req` has no effect.
- R6: In fault standby only a power-button edge wakes the block, and the return uses the fault delay; wake events are ignored.
- R7: Any bit of `rst_req` enters restart standby (`state_o`=4) with both enables high; once all bits are low a return with the fault delay starts, and a reset bit that rises again during that return goes back to state 4.
- R8: Restart wins over fault, and fault wins over request entry; both abort request standby and a return that began from it.
- R9: On a fault or restart entry every unlocked group is reset to its default and writes in that cycle are dropped; lock bits are sticky; a locked group ignores writes and keeps its value. Group bit 0: request delay and both off enables; bit 1: fault delay; bit 2: fault enable.
- R10: In return, while `supply_bad` or `work_rst` is high, the block stays in state 5 after its count has run out.
- R11: An input pin change is first acted on at the third rising clock edge (two-flop synchronizer, then the state register); button and wake inputs act on rising edges only, so a held level wakes at most once.
- R12: The return counter steps down by one per clock edge; with a loaded value D and no hold, working is reached D+1 edges after state 5 is entered, so D=0 reaches working on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Standby clock |
| rst | input | 1 | Synchronous active-high standby reset |
| slp_clk_en | input | 1 | Sleep-clock indication, asynchronous |
| fault_req | input | N_FLT | Fault sources (low power, thermal, fail-safe, power fail), asynchronous |
| rst_req | input | N_RSR | Restart reset sources, asynchronous |
| pwr_btn | input | 1 | Power button, asynchronous |
| wake_evt | input | 1 | Other wake events (alarm, device), asynchronous |
| supply_bad | input | 1 | Main supply reported invalid, holds standby |
| work_rst | input | 1 | Working-domain reset, holds standby |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_lock_set | input | 3 | Lock bits ORed into the lock register on a write |
| cfg_norm_dly | input | DLY_W | Request-return delay write value |
| cfg_flt_dly | input | DLY_W | Fault/restart-return delay write value |
| cfg_main_off_en | input | 1 | Request entry turns the main supply off |
| cfg_aux_off_en | input | 1 | Request entry turns the auxiliary supply off |
| cfg_fault_en | input | 1 | Enables fault entry |
| main_en | output | 1 | Main supply enable, registered |
| aux_en | output | 1 | Auxiliary supply enable, registered |
| state_o | output | 3 | State code: 0 reset standby, 1 working, 2 request, 3 fault, 4 restart, 5 return |

## Verification
The properties assume the event inputs behave as slow level signals that the synchronizer can sample, so the state code and the synchronized hold and reset levels they watch already reflect three-edge latency. They also take for granted that `rst` is applied at start. The stimulus changes every pin only at falling clock edges and holds each pulse for at least two cycles, so no event is lost in the synchronizer. The reference model in the bench applies the same three-edge latency to every pin.

// File: rtl/sby_pwr_pkg.sv
package sby_pwr_pkg;

  typedef enum logic [2:0] {
    ST_RSTSBY  = 3'd0,
    ST_WORK    = 3'd1,
    ST_SBY_NRM = 3'd2,
    ST_SBY_FLT = 3'd3,
    ST_SBY_RSR = 3'd4,
    ST_RETURN  = 3'd5
  } pwr_state_e;

  typedef enum logic [1:0] {
    RK_NRM = 2'd0,
    RK_FLT = 2'd1,
    RK_RSR = 2'd2
  } ret_kind_e;

  localparam int LOCK_GROUPS = 3;
  localparam int LK_NRM = 0;
  localparam int LK_FLT_DLY = 1;
  localparam int LK_FLT_EN = 2;

endpackage

// File: rtl/sby_sync.sv
module sby_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/sby_cfg_regs.sv
module sby_cfg_regs
  import sby_pwr_pkg::*;
#(
  parameter int DLY_W        = 8,
  parameter int NORM_DLY_DEF = 3,
  parameter int FLT_DLY_DEF  = 5
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   clr,
  input  logic                   we,
  input  logic [LOCK_GROUPS-1:0] lock_set,
  input  logic [DLY_W-1:0]       w_norm_dly,
  input  logic [DLY_W-1:0]       w_flt_dly,
  input  logic                   w_main_off,
  input  logic                   w_aux_off,
  input  logic                   w_fault_en,
  output logic [DLY_W-1:0]       norm_dly,
  output logic [DLY_W-1:0]       flt_dly,
  output logic                   main_off_en,
  output logic                   aux_off_en,
  output logic                   fault_en
);

  localparam logic [DLY_W-1:0] NORM_RST = DLY_W'(NORM_DLY_DEF);
  localparam logic [DLY_W-1:0] FLT_RST  = DLY_W'(FLT_DLY_DEF);

  logic [LOCK_GROUPS-1:0] lock_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q      <= '0;
      norm_dly    <= NORM_RST;
      flt_dly     <= FLT_RST;
      main_off_en <= 1'b0;
      aux_off_en  <= 1'b0;
      fault_en    <= 1'b0;
    end else if (clr) begin
      if (!lock_q[LK_NRM]) begin
        norm_dly    <= NORM_RST;
        main_off_en <= 1'b0;
        aux_off_en  <= 1'b0;
      end
      if (!lock_q[LK_FLT_DLY]) flt_dly  <= FLT_RST;
      if (!lock_q[LK_FLT_EN])  fault_en <= 1'b0;
    end else if (we) begin
      if (!lock_q[LK_NRM]) begin
        norm_dly    <= w_norm_dly;
        main_off_en <= w_main_off;
        aux_off_en  <= w_aux_off;
      end
      if (!lock_q[LK_FLT_DLY]) flt_dly  <= w_flt_dly;
      if (!lock_q[LK_FLT_EN])  fault_en <= w_fault_en;
      lock_q <= lock_q | lock_set;
    end
  end

endmodule

// File: rtl/sby_pwr_fsm.sv
module sby_pwr_fsm
  import sby_pwr_pkg::*;
#(
  parameter int DLY_W = 8,
  parameter int N_FLT = 4,
  parameter int N_RSR = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             slp_en,
  input  logic [N_FLT-1:0] flt,
  input  logic [N_RSR-1:0] rsr,
  input  logic             btn,
  input  logic             wk,
  input  logic             hold,
  input  logic [DLY_W-1:0] norm_dly,
  input  logic [DLY_W-1:0] flt_dly,
  input  logic             main_off_en,
  input  logic             aux_off_en,
  input  logic             fault_en,
  output pwr_state_e       state,
  output logic             main_en,
  output logic             aux_en,
  output logic             cfg_clr,
  output logic [DLY_W-1:0] cnt
);

  pwr_state_e       st_n;
  ret_kind_e        kind_q, kind_n;
  logic [DLY_W-1:0] cnt_n;
  logic             main_n, aux_n;
  logic             btn_d, wk_d;
  logic             btn_e, wk_e, rsr_hit, flt_hit, take_rsr, take_flt;

  assign btn_e   = btn & ~btn_d;
  assign wk_e    = wk & ~wk_d;
  assign rsr_hit = |rsr;
  assign flt_hit = fault_en & (|flt);

  always_comb begin
    take_rsr = 1'b0;
    take_flt = 1'b0;
    case (state)
      ST_WORK, ST_SBY_NRM: begin
        take_rsr = rsr_hit;
        take_flt = flt_hit;
      end
      ST_RETURN: begin
        if (kind_q == RK_NRM) begin
          take_rsr = rsr_hit;
          take_flt = flt_hit;
        end else if (kind_q == RK_RSR) begin
          take_rsr = rsr_hit;
        end
      end
      default: ;
    endcase
  end

  always_comb begin
    st_n    = state;
    kind_n  = kind_q;
    cnt_n   = cnt;
    main_n  = main_en;
    aux_n   = aux_en;
    cfg_clr = 1'b0;
    if (take_rsr) begin
      st_n    = ST_SBY_RSR;
      main_n  = 1'b1;
      aux_n   = 1'b1;
      cfg_clr = 1'b1;
    end else if (take_flt) begin
      st_n    = ST_SBY_FLT;
      main_n  = 1'b0;
      aux_n   = 1'b0;
      cfg_clr = 1'b1;
    end else begin
      case (state)
        ST_RSTSBY: if (btn_e) begin
          st_n   = ST_RETURN;
          cnt_n  = flt_dly;
          kind_n = RK_FLT;
        end
        ST_WORK: if (slp_en && (main_off_en || aux_off_en)) begin
          st_n   = ST_SBY_NRM;
          main_n = ~main_off_en;
          aux_n  = ~aux_off_en;
        end
        ST_SBY_NRM: if (btn_e || wk_e) begin
          st_n   = ST_RETURN;
          cnt_n  = norm_dly;
          kind_n = RK_NRM;
        end
        ST_SBY_FLT: if (btn_e) begin
          st_n   = ST_RETURN;
          cnt_n  = flt_dly;
          kind_n = RK_FLT;
        end
        ST_SBY_RSR: if (!rsr_hit) begin
          st_n   = ST_RETURN;
          cnt_n  = flt_dly;
          kind_n = RK_RSR;
        end
        ST_RETURN: begin
          if (cnt != '0) begin
            cnt_n = cnt - DLY_W'(1);
          end else if (!hold) begin
            st_n   = ST_WORK;
            main_n = 1'b1;
            aux_n  = 1'b1;
          end
        end
        default: st_n = ST_RSTSBY;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_RSTSBY;
      kind_q  <= RK_NRM;
      cnt     <= '0;
      main_en <= 1'b0;
      aux_en  <= 1'b0;
      btn_d   <= 1'b0;
      wk_d    <= 1'b0;
    end else begin
      state   <= st_n;
      kind_q  <= kind_n;
      cnt     <= cnt_n;
      main_en <= main_n;
      aux_en  <= aux_n;
      btn_d   <= btn;
      wk_d    <= wk;
    end
  end

endmodule

// File: rtl/sby_pwr_seq.sv
module sby_pwr_seq
  import sby_pwr_pkg::*;
#(
  parameter int DLY_W        = 8,
  parameter int NORM_DLY_DEF = 3,
  parameter int FLT_DLY_DEF  = 5,
  parameter int N_FLT        = 4,
  parameter int N_RSR        = 5,
  parameter int SYNC_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             slp_clk_en,
  input  logic [N_FLT-1:0] fault_req,
  input  logic [N_RSR-1:0] rst_req,
  input  logic             pwr_btn,
  input  logic             wake_evt,
  input  logic             supply_bad,
  input  logic             work_rst,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_lock_set,
  input  logic [DLY_W-1:0] cfg_norm_dly,
  input  logic [DLY_W-1:0] cfg_flt_dly,
  input  logic             cfg_main_off_en,
  input  logic             cfg_aux_off_en,
  input  logic             cfg_fault_en,
  output logic             main_en,
  output logic             aux_en,
  output logic [2:0]       state_o
);

  localparam int SV_W     = N_FLT + N_RSR + 5;
  localparam int B_WRST   = 0;
  localparam int B_SBAD   = 1;
  localparam int B_WK     = 2;
  localparam int B_BTN    = 3;
  localparam int B_RSR    = 4;
  localparam int B_FLT    = B_RSR + N_RSR;
  localparam int B_SLP    = SV_W - 1;

  logic [SV_W-1:0]  raw_v, syn_v;
  logic             hold_s, rsr_any, cfg_clr;
  logic [DLY_W-1:0] norm_dly, flt_dly, ret_cnt;
  logic             main_off_en, aux_off_en, fault_en;
  pwr_state_e       state;

  assign raw_v = {slp_clk_en, fault_req, rst_req, pwr_btn, wake_evt, supply_bad, work_rst};

  sby_sync #(.W(SV_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_v),
    .q   (syn_v)
  );

  assign hold_s  = syn_v[B_SBAD] | syn_v[B_WRST];
  assign rsr_any = |syn_v[B_RSR +: N_RSR];

  sby_cfg_regs #(
    .DLY_W        (DLY_W),
    .NORM_DLY_DEF (NORM_DLY_DEF),
    .FLT_DLY_DEF  (FLT_DLY_DEF)
  ) u_cfg (
    .clk         (clk),
    .rst         (rst),
    .clr         (cfg_clr),
    .we          (cfg_we),
    .lock_set    (cfg_lock_set),
    .w_norm_dly  (cfg_norm_dly),
    .w_flt_dly   (cfg_flt_dly),
    .w_main_off  (cfg_main_off_en),
    .w_aux_off   (cfg_aux_off_en),
    .w_fault_en  (cfg_fault_en),
    .norm_dly    (norm_dly),
    .flt_dly     (flt_dly),
    .main_off_en (main_off_en),
    .aux_off_en  (aux_off_en),
    .fault_en    (fault_en)
  );

  sby_pwr_fsm #(.DLY_W(DLY_W), .N_FLT(N_FLT), .N_RSR(N_RSR)) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .slp_en      (syn_v[B_SLP]),
    .flt         (syn_v[B_FLT +: N_FLT]),
    .rsr         (syn_v[B_RSR +: N_RSR]),
    .btn         (syn_v[B_BTN]),
    .wk          (syn_v[B_WK]),
    .hold        (hold_s),
    .norm_dly    (norm_dly),
    .flt_dly     (flt_dly),
    .main_off_en (main_off_en),
    .aux_off_en  (aux_off_en),
    .fault_en    (fault_en),
    .state       (state),
    .main_en     (main_en),
    .aux_en      (aux_en),
    .cfg_clr     (cfg_clr),
    .cnt         (ret_cnt)
  );

  assign state_o = state;

endmodule

// File: rtl/sby_pwr_seq_chk.sv
module sby_pwr_seq_chk
  import sby_pwr_pkg::*;
#(
  parameter int DLY_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             main_en,
  input logic             aux_en,
  input logic [2:0]       state_o,
  input logic [DLY_W-1:0] ret_cnt,
  input logic             hold_s,
  input logic             rsr_any
);

  a_r1_reset_power_off: assert property (@(posedge clk)
    rst |=> (state_o == ST_RSTSBY && !main_en && !aux_en));

  a_r2_work_both_on: assert property (@(posedge clk) disable iff (rst)
    (state_o == ST_WORK) |-> (main_en && aux_en));

  a_r5_fault_power_off: assert property (@(posedge clk) disable iff (rst)
    (state_o == ST_SBY_FLT) |-> (!main_en && !aux_en));

  a_r7_restart_power_on: assert property (@(posedge clk) disable iff (rst)
    (state_o == ST_SBY_RSR) |-> (main_en && aux_en));

  a_r7_restart_held: assert property (@(posedge clk) disable iff (rst)
    (state_o == ST_SBY_RSR && rsr_any) |=> (state_o == ST_SBY_RSR));

  a_r10_hold_blocks_work: assert property (@(posedge clk) disable iff (rst)
    (state_o == ST_RETURN && hold_s) |=> (state_o != ST_WORK));

  a_r12_count_steps_down: assert property (@(posedge clk) disable iff (rst)
    (state_o == ST_RETURN && ret_cnt != '0) |=>
      (state_o != ST_RETURN || ret_cnt == $past(ret_cnt) - DLY_W'(1)));

  a_r12_no_early_work: assert property (@(posedge clk) disable iff (rst)
    (state_o == ST_RETURN && ret_cnt != '0) |=> (state_o != ST_WORK));

endmodule

bind sby_pwr_seq sby_pwr_seq_chk #(.DLY_W(DLY_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .main_en (main_en),
  .aux_en  (aux_en),
  .state_o (state_o),
  .ret_cnt (ret_cnt),
  .hold_s  (hold_s),
  .rsr_any (rsr_any)
);

// File: tb/sby_pwr_seq_tb.sv
module sby_pwr_seq_tb;

  localparam int DLY_W = 8;
  localparam int NDEF  = 3;
  localparam int FDEF  = 5;
  localparam int NF    = 4;
  localparam int NR    = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic slp_clk_en = 0, pwr_btn = 0, wake_evt = 0, supply_bad = 0, work_rst = 0;
  logic [NF-1:0] fault_req = '0;
  logic [NR-1:0] rst_req = '0;
  logic cfg_we = 0, cfg_main_off_en = 0, cfg_aux_off_en = 0, cfg_fault_en = 0;
  logic [2:0] cfg_lock_set = '0;
  logic [DLY_W-1:0] cfg_norm_dly = '0, cfg_flt_dly = '0;
  logic main_en, aux_en;
  logic [2:0] state_o;

  always #4 clk = ~clk;

  sby_pwr_seq #(.DLY_W(DLY_W), .NORM_DLY_DEF(NDEF), .FLT_DLY_DEF(FDEF),
                .N_FLT(NF), .N_RSR(NR), .SYNC_STAGES(2)) u_dut (
    .clk, .rst, .slp_clk_en, .fault_req, .rst_req, .pwr_btn, .wake_evt,
    .supply_bad, .work_rst, .cfg_we, .cfg_lock_set, .cfg_norm_dly, .cfg_flt_dly,
    .cfg_main_off_en, .cfg_aux_off_en, .cfg_fault_en, .main_en, .aux_en, .state_o);

  int n_vec = 0, n_bad = 0;
  bit done = 0;
  string cur_req = "R1";

  // reference model: pin history, state, configuration
  typedef struct { bit slp, btn, wk, hold, rsr, flt; } pins_t;
  pins_t hq[$];
  bit prev_btn, prev_wk;
  int m_st, m_cnt, m_kind;   // kind: 0 request, 1 fault, 2 restart
  bit m_main, m_aux;
  int m_nd, m_fd;
  bit m_moe, m_aoe, m_fe;
  bit [2:0] m_lk;

  function automatic pins_t sample_pins();
    pins_t p;
    p.slp = slp_clk_en; p.btn = pwr_btn; p.wk = wake_evt;
    p.hold = supply_bad | work_rst; p.rsr = |rst_req; p.flt = |fault_req;
    return p;
  endfunction

  task automatic model_reset();
    pins_t z;
    z = '{0, 0, 0, 0, 0, 0};
    hq = {z, z};
    prev_btn = 0; prev_wk = 0;
    m_st = 0; m_cnt = 0; m_kind = 0; m_main = 0; m_aux = 0;
    m_nd = NDEF; m_fd = FDEF; m_moe = 0; m_aoe = 0; m_fe = 0; m_lk = 0;
  endtask

  task automatic model_step();
    pins_t p;
    bit be, we_, clr, go_r, go_f;
    if (rst) begin model_reset(); return; end
    p = hq[0];
    be  = p.btn && !prev_btn;
    we_ = p.wk && !prev_wk;
    clr = 0;
    go_r = 0; go_f = 0;
    if (m_st == 1 || m_st == 2 || (m_st == 5 && m_kind == 0)) begin
      go_r = p.rsr; go_f = p.flt && m_fe;
    end else if (m_st == 5 && m_kind == 2) go_r = p.rsr;
    if (go_r) begin
      m_st = 4; m_main = 1; m_aux = 1; clr = 1;
    end else if (go_f) begin
      m_st = 3; m_main = 0; m_aux = 0; clr = 1;
    end else if (m_st == 0 && be) begin
      m_st = 5; m_cnt = m_fd; m_kind = 1;
    end else if (m_st == 1 && p.slp && (m_moe || m_aoe)) begin
      m_st = 2; m_main = !m_moe; m_aux = !m_aoe;
    end else if (m_st == 2 && (be || we_)) begin
      m_st = 5; m_cnt = m_nd; m_kind = 0;
    end else if (m_st == 3 && be) begin
      m_st = 5; m_cnt = m_fd; m_kind = 1;
    end else if (m_st == 4 && !p.rsr) begin
      m_st = 5; m_cnt = m_fd; m_kind = 2;
    end else if (m_st == 5) begin
      if (m_cnt > 0) m_cnt--;
      else if (!p.hold) begin m_st = 1; m_main = 1; m_aux = 1; end
    end
    if (clr) begin
      if (!m_lk[0]) begin m_nd = NDEF; m_moe = 0; m_aoe = 0; end
      if (!m_lk[1]) m_fd = FDEF;
      if (!m_lk[2]) m_fe = 0;
    end else if (cfg_we) begin
      if (!m_lk[0]) begin m_nd = cfg_norm_dly; m_moe = cfg_main_off_en; m_aoe = cfg_aux_off_en; end
      if (!m_lk[1]) m_fd = cfg_flt_dly;
      if (!m_lk[2]) m_fe = cfg_fault_en;
      m_lk = m_lk | cfg_lock_set;
    end
    prev_btn = p.btn; prev_wk = p.wk;
    void'(hq.pop_front());
    hq.push_back(sample_pins());
  endtask

  task automatic cyc();
    @(negedge clk);
    model_step();
    n_vec++;
    if (state_o !== 3'(m_st) || main_en !== m_main || aux_en !== m_aux) begin
      n_bad++;
      $display("FAIL %s: state/main/aux actual %0d/%0b/%0b expected %0d/%0b/%0b at %0t",
               cur_req, state_o, main_en, aux_en, m_st, m_main, m_aux, $time);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic expect_st(input string req, input int st, input bit mn, input bit ax);
    n_vec++;
    if (state_o !== 3'(st) || main_en !== mn || aux_en !== ax) begin
      n_bad++;
      $display("FAIL %s: state/main/aux actual %0d/%0b/%0b expected %0d/%0b/%0b",
               req, state_o, main_en, aux_en, st, mn, ax);
    end
  endtask

  task automatic wr_cfg(input int nd, input int fd, input bit moe, input bit aoe,
                        input bit fe, input bit [2:0] lk);
    cfg_we = 1; cfg_norm_dly = DLY_W'(nd); cfg_flt_dly = DLY_W'(fd);
    cfg_main_off_en = moe; cfg_aux_off_en = aoe; cfg_fault_en = fe; cfg_lock_set = lk;
    cyc();
    cfg_we = 0; cfg_lock_set = '0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    model_reset();
    // R1: reset state
    cur_req = "R1";
    cycles(3);
    expect_st("R1", 0, 0, 0);
    rst = 0;
    cycles(2);

    // R2: wake event ignored in reset standby
    cur_req = "R2";
    wake_evt = 1; cycles(2); wake_evt = 0; cycles(5);
    expect_st("R2", 0, 0, 0);

    // R11: held button acts at the third edge, fault delay 1
    wr_cfg(2, 1, 1, 1, 1, 3'b000);
    cur_req = "R11";
    pwr_btn = 1;
    cycles(2);
    expect_st("R11", 0, 0, 0);
    cyc();
    expect_st("R11", 5, 0, 0);
    cur_req = "R2";
    cycles(4);
    expect_st("R2", 1, 1, 1);

    // R3: request entry with only aux off; held button gives no wake
    wr_cfg(2, 1, 0, 1, 1, 3'b000);
    cur_req = "R3";
    slp_clk_en = 1; cycles(4); slp_clk_en = 0;
    expect_st("R3", 2, 1, 0);
    cur_req = "R11";
    cycles(6);
    expect_st("R11", 2, 1, 0);
    pwr_btn = 0; cycles(3);

    // R4: wake event returns with request delay 2
    cur_req = "R4";
    wake_evt = 1; cycles(2); wake_evt = 0;
    cycles(1);
    expect_st("R4", 5, 1, 0);
    cycles(2);
    expect_st("R4", 5, 1, 0);
    cyc();
    expect_st("R4", 1, 1, 1);

    // R3: neither off enable set -> no entry
    wr_cfg(2, 1, 0, 0, 1, 3'b000);
    cur_req = "R3";
    slp_clk_en = 1; cycles(6); slp_clk_en = 0;
    expect_st("R3", 1, 1, 1);

    // R5: fault ignored while disabled
    wr_cfg(6, 1, 0, 0, 0, 3'b000);
    cur_req = "R5";
    fault_req = 4'b0100; cycles(6); fault_req = '0; cycles(3);
    expect_st("R5", 1, 1, 1);

    // R9/R5: lock fault delay at 0, then fault entry
    wr_cfg(6, 0, 0, 0, 1, 3'b010);
    cur_req = "R5";
    fault_req = 4'b0010; cycles(4); fault_req = '0;
    expect_st("R5", 3, 0, 0);
    // R6: wake event ignored in fault standby
    cur_req = "R6";
    wake_evt = 1; cycles(2); wake_evt = 0; cycles(5);
    expect_st("R6", 3, 0, 0);
    // R12: locked delay 0 -> work on the next edge after return
    pwr_btn = 1; cycles(2); pwr_btn = 0;
    cyc();
    expect_st("R6", 5, 0, 0);
    cur_req = "R12";
    cyc();
    expect_st("R12", 1, 1, 1);

    // R9: unlocked fault enable returned to 0, fault has no effect
    cur_req = "R9";
    fault_req = 4'b0001; cycles(6); fault_req = '0; cycles(3);
    expect_st("R9", 1, 1, 1);

    // R8: request standby aborted, restart beats fault
    wr_cfg(4, 7, 1, 1, 1, 3'b000);
    cur_req = "R8";
    slp_clk_en = 1; cycles(4);
    expect_st("R8", 2, 0, 0);
    rst_req = 5'b01000; fault_req = 4'b0100; cycles(3);
    expect_st("R8", 4, 1, 1);
    slp_clk_en = 0; fault_req = '0;
    // R10: hold keeps return from completing
    cur_req = "R10";
    supply_bad = 1; cycles(3);
    rst_req = '0; cycles(8);
    expect_st("R10", 5, 1, 1);
    // R7: reset reasserted during return
    cur_req = "R7";
    rst_req = 5'b00001; cycles(3);
    expect_st("R7", 4, 1, 1);
    rst_req = '0; cycles(3);
    cur_req = "R10";
    work_rst = 1; supply_bad = 0; cycles(6);
    expect_st("R10", 5, 1, 1);
    work_rst = 0;
    // R9: locked delay stayed 0 despite write of 7
    cur_req = "R9";
    cycles(3);
    expect_st("R9", 1, 1, 1);

    // R8: fault aborts a return begun from request standby
    wr_cfg(10, 0, 1, 0, 1, 3'b000);
    cur_req = "R8";
    slp_clk_en = 1; cycles(4); slp_clk_en = 0;
    expect_st("R8", 2, 0, 1);
    wake_evt = 1; cycles(2); wake_evt = 0; cycles(3);
    expect_st("R8", 5, 0, 1);
    fault_req = 4'b1000; cycles(3); fault_req = '0;
    expect_st("R8", 3, 0, 0);
    cur_req = "R6";
    pwr_btn = 1; cycles(2); pwr_btn = 0; cycles(4);
    expect_st("R6", 1, 1, 1);

    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R11 watchdog: actual run unfinished after %0d cycles, expected finish", 200000);
      summary();
      $finish;
    end
  end

endmodule